// File: doc/BRIEF.md
# Dual-Speed Startup Clock Selector

This block supplies the core clock from one of two sources. One is an internal oscillator that is ready almost at once but runs slowly. The other is a fast source that needs time to settle. After reset the core runs at once from the internal source. The fast source is enabled at the same moment. Its ready indication has to stay high for a programmable number of internal-clock cycles before the block trusts it. The block then moves the core onto the fast source through a glitch-free two-branch switch.

If the fast source later drops its ready indication, the block returns the core to the internal source. It also raises a fault flag that stays set until the next reset. A power-of-two divider, set by a 3-bit software field, sits behind the switch. It lowers the delivered frequency to save dynamic power, and it takes a new ratio only at the end of a full divided period.

Top module: `dual_start_clksel`

## Requirements
- R1: While `rst_n` is low and just after it rises, `fast_en` is 1, `on_fast` is 0 and `fault` is 0, and `core_clk` follows the internal clock undivided (ratio 1).
- R2: The core is not moved to the fast source until `fast_rdy` has been high without a break for at least `qual_cycles` internal-clock cycles.
- R3: Any low level on `fast_rdy` before qualification completes restarts the qualification count from zero.
- R4: Once qualification completes and no fault is set, `on_fast` goes to 1 and `core_clk` is derived from `clk_fast`.
- R5: The two source branches are never enabled together. During source or ratio changes, `core_clk` shows no high or low pulse shorter than half a period of the faster source.
- R6: `core_clk` has a period of 2^`div_sel` periods of the selected source (`div_sel` = 0 gives ratio 1, 7 gives ratio 128), with a 50 % duty cycle.
- R7: If `fast_rdy` falls after the fast source has been qualified, `fault` goes to 1 and the core returns to the internal source. `fault` then stays at 1 until reset, and the fast source is not selected again even if `fast_rdy` returns.
- R8: A new `div_sel` value takes effect only at the boundary of a divided period, so the period in progress completes at the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator clock: quick to start, slow |
| clk_fast | input | 1 | High-speed source clock: slow to settle |
| rst_n | input | 1 | Asynchronous active-low reset (also used on wake) |
| fast_rdy | input | 1 | Ready or lock level from the fast source (asynchronous) |
| qual_cycles | input | QUAL_W | Number of internal cycles `fast_rdy` must stay high |
| div_sel | input | 3 | Divide ratio exponent: ratio = 2^div_sel |
| fast_en | output | 1 | Enable to the fast source, high from reset onward |
| core_clk | output | 1 | Divided clock delivered to the core |
| on_fast | output | 1 | High while the fast branch drives the core |
| fault | output | 1 | Sticky flag: fast source lost ready after qualification |

## Verification
`fast_rdy` passes two synchronizer stages before it is counted. After that, stability is registered, and the switch request takes one more internal register. So the earliest switch comes about `qual_cycles` + 4 internal cycles after `fast_rdy` rises, plus two falling edges of each clock in the switch. The bench therefore checks that `on_fast` is still low `qual_cycles` cycles after the rise and high 14 cycles later. A fault appears three internal edges after `fast_rdy` falls, and the bench samples it eight cycles later. A new divide ratio passes one sampling flop and then waits for the next period boundary. For that reason the bench discards two whole `core_clk` periods before it timestamps edges to measure the period and high time, except in the directed case that times the very period in progress.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int MAX_LOG = 7;
  localparam int SEL_W   = $clog2(MAX_LOG + 1);
  localparam int RATIO_W = MAX_LOG + 1;

  // divide ratio selected by the software field
  function automatic logic [RATIO_W-1:0] ratio_of(input logic [SEL_W-1:0] sel);
    return RATIO_W'(1) << sel;
  endfunction

  // source cycles spent high in one divided period
  function automatic logic [RATIO_W-1:0] high_len(input logic [RATIO_W-1:0] ratio);
    return ratio >> 1;
  endfunction
endpackage

// File: rtl/ready_qualifier.sv
module ready_qualifier #(
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rdy_async,
  input  logic [QW-1:0] qual,
  output logic          rdy_s,
  output logic          stable,
  output logic          want,
  output logic          fault
);
  logic [1:0]    sync_q;
  logic [QW-1:0] cnt_q;
  logic [QW:0]   cnt_inc;

  assign rdy_s   = sync_q[1];
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      stable <= 1'b0;
      want   <= 1'b0;
      fault  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rdy_async};
      if (!rdy_s) begin
        cnt_q  <= '0;
        stable <= 1'b0;
      end else begin
        if (cnt_q != qual) cnt_q <= cnt_inc[QW-1:0];
        stable <= (cnt_inc >= {1'b0, qual});
      end
      fault <= fault | (want & ~rdy_s);
      want  <= stable & ~fault;
    end
  end
endmodule

// File: rtl/glitchfree_mux.sv
module glitchfree_mux (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic pick_b,
  output logic en_a,
  output logic en_b,
  output logic clk_o
);
  logic a_s1, b_s1;

  // branch A (reset default) re-enables only when B is fully off
  always_ff @(negedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      a_s1 <= 1'b1;
      en_a <= 1'b1;
    end else begin
      a_s1 <= ~pick_b & ~(en_b | b_s1);
      en_a <= a_s1;
    end
  end

  always_ff @(negedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      b_s1 <= 1'b0;
      en_b <= 1'b0;
    end else begin
      b_s1 <= pick_b & ~(en_a | a_s1);
      en_b <= b_s1;
    end
  end

  assign clk_o = (clk_a & en_a) | (clk_b & en_b);
endmodule

// File: rtl/pow2_divider.sv
module pow2_divider
  import clksel_pkg::*;
(
  input  logic               clk_src,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   sel,
  output logic [RATIO_W-1:0] cnt,
  output logic [RATIO_W-1:0] ratio_act,
  output logic               clk_o
);
  logic [SEL_W-1:0]   sel_q;
  logic               div_q;
  logic               last;
  logic [RATIO_W-1:0] cnt_nx;

  assign last   = (cnt == ratio_act - 1'b1);
  assign cnt_nx = cnt + 1'b1;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      cnt       <= '0;
      ratio_act <= RATIO_W'(1);
      div_q     <= 1'b1;
    end else begin
      sel_q <= sel;
      if (last) begin
        cnt       <= '0;
        ratio_act <= ratio_of(sel_q);
        div_q     <= 1'b1;
      end else begin
        cnt   <= cnt_nx;
        div_q <= (cnt_nx < high_len(ratio_act));
      end
    end
  end

  assign clk_o = (ratio_act == RATIO_W'(1)) ? clk_src : div_q;
endmodule

// File: rtl/dual_start_clksel.sv
module dual_start_clksel
  import clksel_pkg::*;
#(
  parameter int QUAL_W = 8
) (
  input  logic              clk_int,
  input  logic              clk_fast,
  input  logic              rst_n,
  input  logic              fast_rdy,
  input  logic [QUAL_W-1:0] qual_cycles,
  input  logic [SEL_W-1:0]  div_sel,
  output logic              fast_en,
  output logic              core_clk,
  output logic              on_fast,
  output logic              fault
);
  logic               rdy_s_w, stable_w, want_w;
  logic               en_int_w, en_fast_w, mux_clk;
  logic [RATIO_W-1:0] div_cnt_w, div_ratio_w;

  assign fast_en = 1'b1;

  ready_qualifier #(.QW(QUAL_W)) u_qual (
    .clk       (clk_int),
    .rst_n     (rst_n),
    .rdy_async (fast_rdy),
    .qual      (qual_cycles),
    .rdy_s     (rdy_s_w),
    .stable    (stable_w),
    .want      (want_w),
    .fault     (fault)
  );

  glitchfree_mux u_mux (
    .clk_a  (clk_int),
    .clk_b  (clk_fast),
    .rst_n  (rst_n),
    .pick_b (want_w),
    .en_a   (en_int_w),
    .en_b   (en_fast_w),
    .clk_o  (mux_clk)
  );

  pow2_divider u_div (
    .clk_src   (mux_clk),
    .rst_n     (rst_n),
    .sel       (div_sel),
    .cnt       (div_cnt_w),
    .ratio_act (div_ratio_w),
    .clk_o     (core_clk)
  );

  assign on_fast = en_fast_w;
endmodule

// File: rtl/clksel_checker.sv
module clksel_checker
  import clksel_pkg::*;
(
  input logic               clk_int,
  input logic               mux_clk,
  input logic               rst_n,
  input logic               rdy_s,
  input logic               stable,
  input logic               want,
  input logic               fault,
  input logic               en_a,
  input logic               en_b,
  input logic [RATIO_W-1:0] div_cnt,
  input logic [RATIO_W-1:0] ratio_act
);
  p_one_branch_r5: assert property (@(posedge clk_int) disable iff (!rst_n)
    !(en_a && en_b));

  p_one_branch_mux_r5: assert property (@(posedge mux_clk) disable iff (!rst_n)
    $countones({en_a, en_b}) <= 1);

  p_qual_needs_ready_r2: assert property (@(posedge clk_int) disable iff (!rst_n)
    stable |-> $past(rdy_s));

  p_drop_restarts_r3: assert property (@(posedge clk_int) disable iff (!rst_n)
    !rdy_s |=> !stable);

  p_fault_sticky_r7: assert property (@(posedge clk_int) disable iff (!rst_n)
    fault |=> fault);

  p_fault_blocks_r7: assert property (@(posedge clk_int) disable iff (!rst_n)
    fault |=> !want);

  p_ratio_at_boundary_r8: assert property (@(posedge mux_clk) disable iff (!rst_n)
    (div_cnt != '0) |-> $stable(ratio_act));
endmodule

bind dual_start_clksel clksel_checker u_chk (
  .clk_int   (clk_int),
  .mux_clk   (mux_clk),
  .rst_n     (rst_n),
  .rdy_s     (rdy_s_w),
  .stable    (stable_w),
  .want      (want_w),
  .fault     (fault),
  .en_a      (en_int_w),
  .en_b      (en_fast_w),
  .div_cnt   (div_cnt_w),
  .ratio_act (div_ratio_w)
);

// File: tb/sim_dual_start_clksel.sv
`timescale 1ns/1ps
module sim_dual_start_clksel;
  localparam real TI = 8.0;   // internal clock, 125 MHz
  localparam real TF = 3.0;   // fast source

  logic       clk_int = 1'b0, clk_fast = 1'b0, rst_n = 1'b1, fast_rdy = 1'b0;
  logic [7:0] qual_cycles = 8'd8;
  logic [2:0] div_sel = 3'd0;
  logic       fast_en, core_clk, on_fast, fault;

  int  vecs = 0, bad = 0;
  bit  done = 0, mon_on = 0;
  real min_w = 1.0e9, last_t = 0.0;

  always #(TI/2) clk_int  = ~clk_int;
  always #(TF/2) clk_fast = ~clk_fast;

  dual_start_clksel u0 (
    .clk_int(clk_int), .clk_fast(clk_fast), .rst_n(rst_n), .fast_rdy(fast_rdy),
    .qual_cycles(qual_cycles), .div_sel(div_sel), .fast_en(fast_en),
    .core_clk(core_clk), .on_fast(on_fast), .fault(fault)
  );

  // pulse-width monitor; zero-time delta events are not pulses
  always @(core_clk) begin
    if (mon_on) begin
      if (($realtime - last_t) > 0.001 && ($realtime - last_t) < min_w)
        min_w = $realtime - last_t;
      last_t = $realtime;
    end
  end

  function automatic real exp_period(input bit fast, input int sel);
    return (fast ? TF : TI) * real'(1 << sel);
  endfunction

  task automatic chk_b(input string req, input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_r(input string req, input string what, input real act, input real exp);
    vecs++;
    if (act - exp > 0.05 || exp - act > 0.05) begin
      bad++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic wait_int(input int n);
    repeat (n) @(posedge clk_int);
    #1;
  endtask

  task automatic measure(output real per, output real hi);
    real t0, t1;
    @(posedge core_clk); t0 = $realtime;
    @(negedge core_clk); t1 = $realtime;
    @(posedge core_clk);
    per = $realtime - t0;
    hi  = t1 - t0;
  endtask

  task automatic check_ratio(input string req, input bit fast, input int sel);
    real p, h;
    div_sel = 3'(sel);
    measure(p, h);
    measure(p, h);
    measure(p, h);
    chk_r(req, $sformatf("period sel=%0d", sel), p, exp_period(fast, sel));
    chk_r(req, $sformatf("high time sel=%0d", sel), h, exp_period(fast, sel) / 2.0);
  endtask

  task automatic run_phase(input int q);
    real p, h, t0;
    mon_on   = 0;
    fast_rdy = 1'b0;
    div_sel  = 3'd0;
    qual_cycles = 8'(q);
    #3 rst_n = 1'b0;
    #17;
    chk_b("R1", "fast_en in reset", int'(fast_en), 1);
    chk_b("R1", "on_fast in reset", int'(on_fast), 0);
    chk_b("R1", "fault in reset", int'(fault), 0);
    #2 rst_n = 1'b1;
    wait_int(2);
    measure(p, h);
    chk_r("R1", "internal period after reset", p, TI);
    chk_b("R1", "fault after reset", int'(fault), 0);
    last_t = $realtime;
    mon_on = 1;

    // R6: random ratios on the internal source
    repeat (3) check_ratio("R6", 1'b0, $urandom_range(0, 7));

    // R8: change during a long period; the old period must finish
    div_sel = 3'd7;
    measure(p, h); measure(p, h);
    @(posedge core_clk); t0 = $realtime;
    #20 div_sel = 3'd0;
    @(posedge core_clk);
    chk_r("R8", "period in progress keeps old ratio", $realtime - t0, exp_period(1'b0, 7));
    measure(p, h);
    chk_r("R8", "next period uses new ratio", p, exp_period(1'b0, 0));

    // R3: interrupted ready must restart the count
    wait_int(1);
    fast_rdy = 1'b1;
    wait_int(q - 1);
    fast_rdy = 1'b0;
    wait_int(3);
    fast_rdy = 1'b1;
    wait_int(q);
    chk_b("R3", "no switch after restart window", int'(on_fast), 0);
    chk_b("R2", "no switch before qualification", int'(on_fast), 0);
    wait_int(14);
    chk_b("R4", "on_fast after qualification", int'(on_fast), 1);
    chk_b("R4", "no fault on clean switch", int'(fault), 0);
    check_ratio("R4", 1'b1, 0);
    repeat (3) check_ratio("R6", 1'b1, $urandom_range(0, 7));

    // R7: loss of ready on the fast source
    div_sel = 3'($urandom_range(0, 3));
    fast_rdy = 1'b0;
    wait_int(8);
    chk_b("R7", "fault after ready loss", int'(fault), 1);
    chk_b("R7", "back on internal", int'(on_fast), 0);
    check_ratio("R7", 1'b0, int'(div_sel));
    fast_rdy = 1'b1;
    wait_int(q + 20);
    chk_b("R7", "fault stays set", int'(fault), 1);
    chk_b("R7", "no reselect of fast", int'(on_fast), 0);
    mon_on = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0C1C));
    run_phase($urandom_range(6, 20));
    run_phase($urandom_range(6, 20));
    vecs++;
    if (min_w < TF / 2.0 - 0.05) begin
      bad++;
      $display("FAIL R5 shortest core_clk pulse: actual %0.3f expected >= %0.3f", min_w, TF / 2.0);
    end
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * TI);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule